// File: doc/BRIEF.md
# Bidirectional Four-Slot Mailbox

This block lets two processors, a host and a microcontroller, pass short messages to each other through shared 32-bit registers. Each side has its own register port, and both ports can read every register. Traffic runs in two independent directions (host to MCU and MCU to host). Each direction holds four slots, and each slot is a command word followed by a data word.

The sender fills a slot by writing the command word and then the data word. The data write marks the slot as full in a status register, which the receiver clears by writing ones. The receiver also owns an enable register. It gets one interrupt line per slot and a combined line. The combined line rises only when every slot of the direction is full and every enable is set. Each port may write only the registers that its role in a direction gives it. All other writes are dropped.

Top module: `mbox_dual`

## Requirements
- R1: After reset every register reads 0 through both ports, and all interrupt outputs are low.
- R2: Address layout: address bit 4 selects the direction (0 = host to MCU, 1 = MCU to host). In the low four bits, offset 2k holds the command word of slot k, 2k+1 the data word of slot k, 8 the enable register and 9 the status register. Both ports read the same full 32-bit word written by the sender.
- R3: A sender write to the data word of slot k sets status bit k one cycle later, whether or not the command word was written first.
- R4: A command-word write leaves the status register unchanged.
- R5: The receiver writing the status register clears each bit written as 1. Bits written as 0 keep their value.
- R6: The per-slot interrupt bit k of a direction is high exactly when status bit k and enable bit k are both 1. Host-to-MCU lines appear on `m_irq`, and MCU-to-host lines appear on `h_irq`.
- R7: The combined interrupt of a direction is high only while all four status bits and all four enable bits are 1. It drops in the cycle after any of those status bits is cleared.
- R8: Some writes are ignored: a port writing the command or data words of the direction it receives, or the enable or status register of the direction it sends.
- R9: When a data write and a clear of the same slot land in the same cycle, the status bit ends up set.
- R10: The enable register keeps only its low four bits, and its upper bits read 0. Offsets 10 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr_en | input | 1 | Host port write strobe |
| h_addr | input | 5 | Host port word address |
| h_wdata | input | 32 | Host port write data |
| h_rdata | output | 32 | Host port read data (combinational from h_addr) |
| m_wr_en | input | 1 | MCU port write strobe |
| m_addr | input | 5 | MCU port word address |
| m_wdata | input | 32 | MCU port write data |
| m_rdata | output | 32 | MCU port read data (combinational from m_addr) |
| h_irq | output | 4 | Per-slot interrupts of the MCU-to-host direction |
| h_irq_all | output | 1 | Combined interrupt of the MCU-to-host direction |
| m_irq | output | 4 | Per-slot interrupts of the host-to-MCU direction |
| m_irq_all | output | 1 | Combined interrupt of the host-to-MCU direction |

## Verification
The assertions rely on the ownership rules. For each direction, only the sender can raise a fill event and only the receiver can raise a clear event, so the two kinds of status change have no other source. The properties assume that the write strobes and addresses are free of X while reset is inactive. The bench keeps to this by driving every input from a known value at reset and changing inputs only at falling clock edges. The bench makes the collision case of R9 happen on purpose, with one write from each port in the same cycle. All other scenarios issue one write per cycle.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;

  typedef enum logic {
    DIR_H2M = 1'b0,
    DIR_M2H = 1'b1
  } mbox_dir_e;

  // Offset decode helpers: slot k uses offsets 2k (command) and 2k+1 (data),
  // followed by the enable and status registers.
  function automatic bit ofs_is_cmd(input int ofs, input int slots);
    return (ofs < 2 * slots) && (ofs % 2 == 0);
  endfunction

  function automatic bit ofs_is_dat(input int ofs, input int slots);
    return (ofs < 2 * slots) && (ofs % 2 == 1);
  endfunction

  function automatic int ofs_slot(input int ofs);
    return ofs / 2;
  endfunction

  function automatic bit ofs_is_en(input int ofs, input int slots);
    return ofs == 2 * slots;
  endfunction

  function automatic bit ofs_is_st(input int ofs, input int slots);
    return ofs == 2 * slots + 1;
  endfunction

  // Status bit update: a fill overrides a clear arriving in the same cycle.
  function automatic logic st_bit_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/mbox_lane.sv
`timescale 1ns/1ps
module mbox_lane
  import mbox_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int DW    = 32,
  parameter int OW    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       snd_we,
  input  logic [OW-1:0]              snd_ofs,
  input  logic [DW-1:0]              snd_wdata,
  input  logic                       rcv_we,
  input  logic [OW-1:0]              rcv_ofs,
  input  logic [SLOTS-1:0]           rcv_wdata,
  output logic [SLOTS-1:0][DW-1:0]   cmd_q,
  output logic [SLOTS-1:0][DW-1:0]   dat_q,
  output logic [SLOTS-1:0]           en_q,
  output logic [SLOTS-1:0]           st_q,
  output logic [SLOTS-1:0]           fill_ev,
  output logic [SLOTS-1:0]           clr_ev,
  output logic [SLOTS-1:0]           irq_slot,
  output logic                       irq_all
);

  logic en_hit;
  logic st_hit;

  assign en_hit = rcv_we && ofs_is_en(int'(rcv_ofs), SLOTS);
  assign st_hit = rcv_we && ofs_is_st(int'(rcv_ofs), SLOTS);
  assign clr_ev = st_hit ? rcv_wdata : '0;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic cmd_hit;
    assign cmd_hit    = snd_we && ofs_is_cmd(int'(snd_ofs), SLOTS) && (ofs_slot(int'(snd_ofs)) == k);
    assign fill_ev[k] = snd_we && ofs_is_dat(int'(snd_ofs), SLOTS) && (ofs_slot(int'(snd_ofs)) == k);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmd_q[k] <= '0;
        dat_q[k] <= '0;
        st_q[k]  <= 1'b0;
      end else begin
        if (cmd_hit)    cmd_q[k] <= snd_wdata;
        if (fill_ev[k]) dat_q[k] <= snd_wdata;
        st_q[k] <= st_bit_next(st_q[k], fill_ev[k], clr_ev[k]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= '0;
    else if (en_hit) en_q <= rcv_wdata;
  end

  assign irq_slot = st_q & en_q;
  assign irq_all  = &irq_slot;

endmodule

// File: rtl/mbox_rdmux.sv
`timescale 1ns/1ps
module mbox_rdmux
  import mbox_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int DW    = 32,
  parameter int OW    = 4
) (
  input  logic [OW:0]                     addr,
  input  logic [1:0][SLOTS-1:0][DW-1:0]   cmd_q,
  input  logic [1:0][SLOTS-1:0][DW-1:0]   dat_q,
  input  logic [1:0][SLOTS-1:0]           en_q,
  input  logic [1:0][SLOTS-1:0]           st_q,
  output logic [DW-1:0]                   rdata
);

  logic d;
  int   ofs;

  always_comb begin
    d     = addr[OW];
    ofs   = int'(addr[OW-1:0]);
    rdata = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (ofs == 2 * k)     rdata = cmd_q[d][k];
      if (ofs == 2 * k + 1) rdata = dat_q[d][k];
    end
    if (ofs_is_en(ofs, SLOTS)) rdata = {{(DW-SLOTS){1'b0}}, en_q[d]};
    if (ofs_is_st(ofs, SLOTS)) rdata = {{(DW-SLOTS){1'b0}}, st_q[d]};
  end

endmodule

// File: rtl/mbox_dual.sv
`timescale 1ns/1ps
module mbox_dual
  import mbox_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int DW    = 32,
  localparam int OW   = $clog2(2 * SLOTS + 2),
  localparam int AW   = OW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_wr_en,
  input  logic [AW-1:0]    h_addr,
  input  logic [DW-1:0]    h_wdata,
  output logic [DW-1:0]    h_rdata,
  input  logic             m_wr_en,
  input  logic [AW-1:0]    m_addr,
  input  logic [DW-1:0]    m_wdata,
  output logic [DW-1:0]    m_rdata,
  output logic [SLOTS-1:0] h_irq,
  output logic             h_irq_all,
  output logic [SLOTS-1:0] m_irq,
  output logic             m_irq_all
);

  logic [1:0][SLOTS-1:0][DW-1:0] cmd_q;
  logic [1:0][SLOTS-1:0][DW-1:0] dat_q;
  logic [1:0][SLOTS-1:0]         en_q;
  logic [1:0][SLOTS-1:0]         st_q;
  logic [1:0][SLOTS-1:0]         fill_ev;
  logic [1:0][SLOTS-1:0]         clr_ev;
  logic [1:0][SLOTS-1:0]         irq_slot;
  logic [1:0]                    irq_all;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic              snd_we;
    logic              rcv_we;
    logic [OW-1:0]     snd_ofs;
    logic [OW-1:0]     rcv_ofs;
    logic [DW-1:0]     snd_wdata;
    logic [SLOTS-1:0]  rcv_wdata;

    if (d == int'(DIR_H2M)) begin : g_h2m
      assign snd_we    = h_wr_en && (h_addr[OW] == 1'(d));
      assign snd_ofs   = h_addr[OW-1:0];
      assign snd_wdata = h_wdata;
      assign rcv_we    = m_wr_en && (m_addr[OW] == 1'(d));
      assign rcv_ofs   = m_addr[OW-1:0];
      assign rcv_wdata = m_wdata[SLOTS-1:0];
    end else begin : g_m2h
      assign snd_we    = m_wr_en && (m_addr[OW] == 1'(d));
      assign snd_ofs   = m_addr[OW-1:0];
      assign snd_wdata = m_wdata;
      assign rcv_we    = h_wr_en && (h_addr[OW] == 1'(d));
      assign rcv_ofs   = h_addr[OW-1:0];
      assign rcv_wdata = h_wdata[SLOTS-1:0];
    end

    mbox_lane #(.SLOTS(SLOTS), .DW(DW), .OW(OW)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .snd_we    (snd_we),
      .snd_ofs   (snd_ofs),
      .snd_wdata (snd_wdata),
      .rcv_we    (rcv_we),
      .rcv_ofs   (rcv_ofs),
      .rcv_wdata (rcv_wdata),
      .cmd_q     (cmd_q[d]),
      .dat_q     (dat_q[d]),
      .en_q      (en_q[d]),
      .st_q      (st_q[d]),
      .fill_ev   (fill_ev[d]),
      .clr_ev    (clr_ev[d]),
      .irq_slot  (irq_slot[d]),
      .irq_all   (irq_all[d])
    );
  end

  mbox_rdmux #(.SLOTS(SLOTS), .DW(DW), .OW(OW)) u_rd_host (
    .addr (h_addr), .cmd_q (cmd_q), .dat_q (dat_q),
    .en_q (en_q), .st_q (st_q), .rdata (h_rdata)
  );

  mbox_rdmux #(.SLOTS(SLOTS), .DW(DW), .OW(OW)) u_rd_mcu (
    .addr (m_addr), .cmd_q (cmd_q), .dat_q (dat_q),
    .en_q (en_q), .st_q (st_q), .rdata (m_rdata)
  );

  assign m_irq     = irq_slot[DIR_H2M];
  assign m_irq_all = irq_all[DIR_H2M];
  assign h_irq     = irq_slot[DIR_M2H];
  assign h_irq_all = irq_all[DIR_M2H];

endmodule

// File: rtl/mbox_dual_chk.sv
`timescale 1ns/1ps
module mbox_dual_chk #(
  parameter int SLOTS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0][SLOTS-1:0]  st_q,
  input logic [1:0][SLOTS-1:0]  en_q,
  input logic [1:0][SLOTS-1:0]  fill_ev,
  input logic [1:0][SLOTS-1:0]  clr_ev,
  input logic [SLOTS-1:0]       h_irq,
  input logic                   h_irq_all,
  input logic [SLOTS-1:0]       m_irq,
  input logic                   m_irq_all
);

  for (genvar d = 0; d < 2; d++) begin : g_d
    for (genvar k = 0; k < SLOTS; k++) begin : g_k
      // R3 / R9: a fill always leaves the bit set, even against a clear
      p_fill_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ev[d][k] |=> st_q[d][k]);
      // R5: a clear without a competing fill empties the bit
      p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ev[d][k] && !fill_ev[d][k]) |=> !st_q[d][k]);
      // R5: with no event the bit holds
      p_status_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_ev[d][k] && !fill_ev[d][k]) |=> $stable(st_q[d][k]));
    end
  end

  // R6: an interrupt line needs its enable
  p_irq_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_irq & ~en_q[0]) == '0) && ((h_irq & ~en_q[1]) == '0));

  // R7: combined line implies every per-slot line
  p_all_implies_slots_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_irq_all |-> (&m_irq)) and (h_irq_all |-> (&h_irq)));

  // R7: an effective clear drops the combined line on the next cycle
  p_clear_drops_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_ev[0] & ~fill_ev[0]) != '0) |=> !m_irq_all);
  p_clear_drops_all_h_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_ev[1] & ~fill_ev[1]) != '0) |=> !h_irq_all);

  // R1: interrupts are low in the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (m_irq == '0 && h_irq == '0 && !m_irq_all && !h_irq_all));

endmodule

bind mbox_dual mbox_dual_chk #(.SLOTS(SLOTS)) u_chk (.*);

// File: tb/test_mbox_dual.sv
`timescale 1ns/1ps
module test_mbox_dual;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_wr_en = 1'b0;
  logic [4:0]  h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic        m_wr_en = 1'b0;
  logic [4:0]  m_addr = '0;
  logic [31:0] m_wdata = '0;
  logic [31:0] m_rdata;
  logic [3:0]  h_irq;
  logic        h_irq_all;
  logic [3:0]  m_irq;
  logic        m_irq_all;

  int n_chk = 0;
  int n_bad = 0;

  mbox_dual i_mbox_dual (.*);

  always #10 clk = ~clk;

  // Address arithmetic stated independently of the RTL: direction at bit 4.
  function automatic logic [4:0] a_cmd(int d, int k); return 5'(d * 16 + k * 2);     endfunction
  function automatic logic [4:0] a_dat(int d, int k); return 5'(d * 16 + k * 2 + 1); endfunction
  function automatic logic [4:0] a_en(int d);         return 5'(d * 16 + 8);         endfunction
  function automatic logic [4:0] a_st(int d);         return 5'(d * 16 + 9);         endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic hw(logic [4:0] a, logic [31:0] v);
    @(negedge clk); h_wr_en = 1'b1; h_addr = a; h_wdata = v;
    @(negedge clk); h_wr_en = 1'b0;
  endtask

  task automatic mw(logic [4:0] a, logic [31:0] v);
    @(negedge clk); m_wr_en = 1'b1; m_addr = a; m_wdata = v;
    @(negedge clk); m_wr_en = 1'b0;
  endtask

  task automatic hr(logic [4:0] a, output logic [31:0] v);
    h_addr = a; #1; v = h_rdata;
  endtask

  task automatic mr(logic [4:0] a, output logic [31:0] v);
    m_addr = a; #1; v = m_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 32; a++) begin
      hr(5'(a), v); chk("R1", "host read after reset", v, 0);
      mr(5'(a), v); chk("R1", "mcu read after reset", v, 0);
    end
    chk("R1", "irq lines after reset", {22'd0, h_irq, h_irq_all, m_irq, m_irq_all}, 0);
  endtask

  task automatic t_slot_fill;
    logic [31:0] v;
    hw(a_cmd(0, 2), 32'hA5A5_0F0F);
    mr(a_st(0), v); chk("R4", "status after command write", v, 0);
    hw(a_dat(0, 2), 32'h1234_5678);
    mr(a_cmd(0, 2), v); chk("R2", "mcu reads cmd slot2", v, 32'hA5A5_0F0F);
    hr(a_dat(0, 2), v); chk("R2", "host reads dat slot2", v, 32'h1234_5678);
    mr(a_st(0), v); chk("R3", "status after data write", v, 32'h4);
    chk("R6", "no irq while disabled", {28'd0, m_irq}, 0);
  endtask

  task automatic t_data_only;
    logic [31:0] v;
    hw(a_dat(0, 1), 32'h7);
    mr(a_st(0), v); chk("R3", "data without command sets bit", v, 32'h6);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    mw(a_en(0), 32'hFFFF_FFF5);
    mr(a_en(0), v); chk("R10", "enable keeps four bits", v, 32'h5);
    chk("R6", "slot irq is status and enable", {28'd0, m_irq}, 32'h4);
    chk("R7", "combined low with partial fill", {31'd0, m_irq_all}, 0);
    for (int o = 10; o < 16; o++) begin
      hr(5'(o), v); chk("R10", "unused offset reads zero", v, 0);
    end
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    mw(a_st(0), 32'h0);
    mr(a_st(0), v); chk("R5", "zero write keeps status", v, 32'h6);
    mw(a_st(0), 32'h2);
    mr(a_st(0), v); chk("R5", "one clears bit1 only", v, 32'h4);
    chk("R6", "irq follows cleared status", {28'd0, m_irq}, 32'h4);
  endtask

  task automatic t_combined;
    logic [31:0] v;
    mw(a_en(0), 32'hF);
    hw(a_dat(0, 0), 32'h10);
    hw(a_dat(0, 1), 32'h11);
    chk("R7", "combined low with three full", {31'd0, m_irq_all}, 0);
    hw(a_dat(0, 3), 32'h13);
    chk("R7", "combined high with all full", {31'd0, m_irq_all}, 1);
    mw(a_st(0), 32'h8);
    chk("R7", "combined drops after one clear", {31'd0, m_irq_all}, 0);
    mr(a_st(0), v); chk("R5", "other bits kept", v, 32'h7);
    mw(a_st(0), 32'hF);
  endtask

  task automatic t_ownership;
    logic [31:0] v;
    hw(a_en(0), 32'h0);
    mr(a_en(0), v); chk("R8", "host cannot write h2m enable", v, 32'hF);
    hw(a_dat(0, 0), 32'h20);
    hw(a_st(0), 32'h1);
    mr(a_st(0), v); chk("R8", "host cannot clear h2m status", v, 32'h1);
    mw(a_cmd(0, 0), 32'hDEAD_0000);
    hr(a_cmd(0, 0), v); chk("R8", "mcu cannot write h2m command", v, 0);
    hw(a_cmd(1, 0), 32'hBEEF_0000);
    mr(a_cmd(1, 0), v); chk("R8", "host cannot write m2h command", v, 0);
    mw(a_st(0), 32'hF);
  endtask

  task automatic t_reverse;
    logic [31:0] v;
    mw(a_cmd(1, 3), 32'hC0C0_0003);
    mw(a_dat(1, 3), 32'hD0D0_0003);
    hw(a_en(1), 32'h8);
    chk("R6", "host irq slot3", {28'd0, h_irq}, 32'h8);
    hr(a_dat(1, 3), v); chk("R2", "host reads m2h data", v, 32'hD0D0_0003);
    mr(a_cmd(1, 3), v); chk("R2", "mcu reads m2h command", v, 32'hC0C0_0003);
    chk("R7", "host combined low", {31'd0, h_irq_all}, 0);
    chk("R6", "m2h traffic leaves mcu irq low", {28'd0, m_irq}, 0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    hw(a_dat(0, 1), 32'h1);
    @(negedge clk);
    h_wr_en = 1'b1; h_addr = a_dat(0, 1); h_wdata = 32'h2;
    m_wr_en = 1'b1; m_addr = a_st(0);     m_wdata = 32'h2;
    @(negedge clk);
    h_wr_en = 1'b0; m_wr_en = 1'b0;
    mr(a_st(0), v); chk("R9", "fill wins over clear", v, 32'h2);
    mr(a_dat(0, 1), v); chk("R9", "new data stored", v, 32'h2);
    chk("R6", "irq after collision", {28'd0, m_irq}, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_slot_fill();
    t_data_only();
    t_enable();
    t_w1c();
    t_combined();
    t_ownership();
    t_reverse();
    t_collide();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule